// File: doc/BRIEF.md
# Hypercube Dimension-Order Message Router

A network of routing nodes that moves short messages between the corners of a binary n-cube. The default cube has three dimensions and so eight nodes. Every node has an n-bit label. Two nodes share a link exactly when their labels differ in one bit. Each node can take a message from its own processor port or from any of its n link inputs. It XORs the message's destination with its own label and picks one move. An all-zero result sends the message to the local delivery port. Otherwise the message goes out on the link of the lowest set bit of the XOR, so each hop fixes one address bit, working upward from bit 0.

Each node holds one message per input in a single register slot. Each output has a round-robin arbiter, and every edge uses a valid/ready handshake. A message carries its destination, a hop counter and a payload. The hop counter goes up by one on every link traversal and is reported with the payload at the destination. The top level builds the whole cube from one node design and adds a reset synchroniser, so the block can be dropped in and tested as a unit.

Top module: `hcube_net`

## Requirements
- R1: A message injected at any node with destination d appears once on the delivery port of node d, with its payload unchanged.
- R2: A node forwards a non-local message on the link of the lowest bit position where its label and the destination differ. For example, 011 to 110 goes through 010, so a message from 010 to 110 that is injected at the same time reaches 110 first.
- R3: The delivered hop count equals the number of bit positions in which the source and destination labels differ, and it never exceeds the dimension.
- R4: A message addressed to the injecting node itself is delivered at that node with a hop count of 0.
- R5: Inputs contending for one output are served round-robin over the input index. Link inputs take indices 0 to n-1 by dimension, and the local input takes index n. After reset, index 0 has priority. Once a grant is shown to a stalled output it stays fixed, and after each accepted transfer priority passes to the index after the winner.
- R6: No message is lost. Messages held back by a stalled delivery port are all delivered, each exactly once, once the port is ready.
- R7: While a delivery port shows valid without ready, its valid, payload and hop count hold unchanged. Link outputs between nodes obey the same rule.
- R8: Right after reset no delivery port is valid and every injection port is ready.
- R9: Each input holds at most one message. The cycle after an injection is accepted, that injection port is not ready until the message has left its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inj_valid | input | 2^DIM | Per-node injection valid |
| inj_dst | input | 2^DIM*DIM | Per-node destination label, node k in bits k*DIM upward |
| inj_data | input | 2^DIM*PW | Per-node payload |
| inj_ready | output | 2^DIM | Per-node injection ready |
| dlv_valid | output | 2^DIM | Per-node delivery valid |
| dlv_data | output | 2^DIM*PW | Per-node delivered payload |
| dlv_hops | output | 2^DIM*HW | Per-node delivered hop count, HW = clog2(DIM+1) |
| dlv_ready | input | 2^DIM | Per-node delivery ready |

## Verification
In a single cycle, a node's local output can be asked for both by a freshly injected message and by messages that arrive on its links. A link output can likewise be wanted both by a local message and by a message in transit. The bench sets up both cases by stalling a delivery port and injecting at the same moment at the destination and at its neighbours, or at two nodes whose routes merge on one link. The order in which the queued payloads come out once the port is ready is compared against the round-robin rule and the dimension-order route. Hop counts for every source/destination pair are compared with a Hamming distance the bench computes itself.

// File: rtl/hcube_pkg.sv
package hcube_pkg;
  // width of a hop counter able to hold 0..dim
  function automatic int hc_hop_width(int dim);
    return (dim < 1) ? 1 : $clog2(dim + 1);
  endfunction

  // width of an index into n items
  function automatic int hc_idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hc_rst_sync.sv
module hc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/hc_route_sel.sv
module hc_route_sel #(
  parameter int DIM = 3
) (
  input  logic [DIM-1:0] own,
  input  logic [DIM-1:0] dst,
  output logic [DIM:0]   port   // one-hot, bit DIM = local delivery
);
  logic [DIM-1:0] diff;
  logic [DIM-1:0] low;

  always_comb begin
    diff = own ^ dst;
    low  = diff & (~diff + DIM'(1));
    port = '0;
    if (diff == '0) port[DIM]     = 1'b1;
    else            port[DIM-1:0] = low;
  end
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb import hcube_pkg::*; #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         accept,
  output logic [N-1:0] gnt
);
  localparam int PTRW = hc_idx_width(N);

  logic [PTRW-1:0] ptr_q, ptr_d;
  logic [N-1:0]    gnt_q, fresh;
  logic            hold_q, hold_d;
  logic            found;
  int              idx;

  // fresh pick, starting one past the last winner
  always_comb begin
    fresh = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 1; k <= N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx[PTRW-1:0]]) begin
        fresh[idx[PTRW-1:0]] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign gnt = hold_q ? gnt_q : fresh;

  always_comb begin
    hold_d = (|gnt) & ~accept;
    ptr_d  = ptr_q;
    if ((|gnt) && accept) begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) ptr_d = PTRW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= PTRW'(N - 1);
      hold_q <= 1'b0;
      gnt_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      hold_q <= hold_d;
      gnt_q  <= gnt;
    end
  end
endmodule

// File: rtl/hc_node.sv
module hc_node import hcube_pkg::*; #(
  parameter int DIM = 3,
  parameter int PW  = 8,
  parameter int OWN = 0,
  localparam int NP = DIM + 1,
  localparam int HW = hc_hop_width(DIM),
  localparam int MW = DIM + HW + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NP-1:0]  in_v,
  input  logic [NP*MW-1:0] in_msg,
  output logic [NP-1:0]  in_rdy,
  output logic [NP-1:0]  out_v,
  output logic [NP*MW-1:0] out_msg,
  input  logic [NP-1:0]  out_rdy
);
  localparam logic [DIM-1:0] OWN_A = DIM'(OWN);

  logic [NP-1:0] slot_v_q, slot_v_d;
  logic [NP-1:0] load, pop;
  logic [MW-1:0] slot_q [NP];
  logic [NP-1:0] route  [NP];   // route[i][o]
  logic [NP-1:0] req    [NP];   // req[o][i]
  logic [NP-1:0] gnt    [NP];   // gnt[o][i]
  logic [MW-1:0] omsg   [NP];

  genvar gi, go;
  generate
    for (gi = 0; gi < NP; gi++) begin : g_in
      hc_route_sel #(.DIM(DIM)) u_sel (
        .own  (OWN_A),
        .dst  (slot_q[gi][MW-1 -: DIM]),
        .port (route[gi])
      );

      always_ff @(posedge clk) begin
        if (load[gi]) slot_q[gi] <= in_msg[gi*MW +: MW];
      end
    end

    for (go = 0; go < NP; go++) begin : g_out
      hc_rr_arb #(.N(NP)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req[go]),
        .accept (out_rdy[go]),
        .gnt    (gnt[go])
      );
      assign out_v[go]             = |gnt[go];
      assign out_msg[go*MW +: MW]  = omsg[go];
    end
  endgenerate

  // request matrix
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req[o][i] = slot_v_q[i] & route[i][o];
      end
    end
  end

  // output multiplexers, hop count bumped on link outputs
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      omsg[o] = '0;
      for (int i = 0; i < NP; i++) begin
        if (gnt[o][i]) omsg[o] = omsg[o] | slot_q[i];
      end
      if (o < DIM) omsg[o][PW +: HW] = omsg[o][PW +: HW] + HW'(1);
    end
  end

  // slot occupancy next state
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      pop[i] = 1'b0;
      for (int o = 0; o < NP; o++) begin
        pop[i] = pop[i] | (gnt[o][i] & out_rdy[o]);
      end
    end
    in_rdy   = ~slot_v_q;
    load     = in_v & in_rdy;
    slot_v_d = (slot_v_q & ~pop) | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_v_q <= '0;
    else        slot_v_q <= slot_v_d;
  end
endmodule

// File: rtl/hcube_net.sv
module hcube_net import hcube_pkg::*; #(
  parameter int DIM = 3,
  parameter int PW  = 8,
  localparam int NODES = 1 << DIM,
  localparam int HW    = hc_hop_width(DIM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NODES-1:0]      inj_valid,
  input  logic [NODES*DIM-1:0]  inj_dst,
  input  logic [NODES*PW-1:0]   inj_data,
  output logic [NODES-1:0]      inj_ready,
  output logic [NODES-1:0]      dlv_valid,
  output logic [NODES*PW-1:0]   dlv_data,
  output logic [NODES*HW-1:0]   dlv_hops,
  input  logic [NODES-1:0]      dlv_ready
);
  localparam int NP = DIM + 1;
  localparam int MW = DIM + HW + PW;

  logic rst_s;

  logic [NP-1:0]    nin_v   [NODES];
  logic [NP-1:0]    nin_rdy [NODES];
  logic [NP*MW-1:0] nin_msg [NODES];
  logic [NP-1:0]    nout_v  [NODES];
  logic [NP-1:0]    nout_rdy[NODES];
  logic [NP*MW-1:0] nout_msg[NODES];

  hc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  genvar gn, gd;
  generate
    for (gn = 0; gn < NODES; gn++) begin : g_node
      hc_node #(.DIM(DIM), .PW(PW), .OWN(gn)) u_node (
        .clk     (clk),
        .rst_n   (rst_s),
        .in_v    (nin_v[gn]),
        .in_msg  (nin_msg[gn]),
        .in_rdy  (nin_rdy[gn]),
        .out_v   (nout_v[gn]),
        .out_msg (nout_msg[gn]),
        .out_rdy (nout_rdy[gn])
      );

      for (gd = 0; gd < DIM; gd++) begin : g_link
        localparam int NB = gn ^ (1 << gd);
        assign nin_v[gn][gd]              = nout_v[NB][gd];
        assign nin_msg[gn][gd*MW +: MW]   = nout_msg[NB][gd*MW +: MW];
        assign nout_rdy[gn][gd]           = nin_rdy[NB][gd];
      end

      assign nin_v[gn][DIM]             = inj_valid[gn];
      assign nin_msg[gn][DIM*MW +: MW]  = {inj_dst[gn*DIM +: DIM], HW'(0), inj_data[gn*PW +: PW]};
      assign inj_ready[gn]              = nin_rdy[gn][DIM];
      assign dlv_valid[gn]              = nout_v[gn][DIM];
      assign dlv_data[gn*PW +: PW]      = nout_msg[gn][DIM*MW +: PW];
      assign dlv_hops[gn*HW +: HW]      = nout_msg[gn][DIM*MW + PW +: HW];
      assign nout_rdy[gn][DIM]          = dlv_ready[gn];
    end
  endgenerate
endmodule

// File: rtl/hcube_chk.sv
module hcube_chk import hcube_pkg::*; #(
  parameter int DIM = 3,
  parameter int PW  = 8,
  localparam int NODES = 1 << DIM,
  localparam int HW    = hc_hop_width(DIM),
  localparam int NP    = DIM + 1,
  localparam int MW    = DIM + HW + PW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NODES-1:0]     inj_valid,
  input logic [NODES-1:0]     inj_ready,
  input logic [NODES-1:0]     dlv_valid,
  input logic [NODES*PW-1:0]  dlv_data,
  input logic [NODES*HW-1:0]  dlv_hops,
  input logic [NODES-1:0]     dlv_ready,
  input logic [NP-1:0]        nout_v   [NODES],
  input logic [NP-1:0]        nout_rdy [NODES],
  input logic [NP*MW-1:0]     nout_msg [NODES]
);
  genvar gn, gd;
  generate
    for (gn = 0; gn < NODES; gn++) begin : g_n
      // R7
      dlv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid[gn] && !dlv_ready[gn] |=> dlv_valid[gn]
          && $stable(dlv_data[gn*PW +: PW]) && $stable(dlv_hops[gn*HW +: HW]));

      // R3
      hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid[gn] |-> (int'(dlv_hops[gn*HW +: HW]) <= DIM));

      // R9
      slot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid[gn] && inj_ready[gn] |=> !inj_ready[gn]);

      for (gd = 0; gd < DIM; gd++) begin : g_d
        // R2
        link_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
          nout_v[gn][gd] |->
            (((nout_msg[gn][gd*MW + MW - 1 -: DIM] ^ DIM'(gn)) & DIM'((1 << (gd + 1)) - 1))
              == DIM'(1 << gd)));

        // R7
        link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
          nout_v[gn][gd] && !nout_rdy[gn][gd] |=> nout_v[gn][gd]
            && $stable(nout_msg[gn][gd*MW +: MW]));
      end
    end
  endgenerate
endmodule

bind hcube_net hcube_chk #(.DIM(DIM), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inj_valid (inj_valid),
  .inj_ready (inj_ready),
  .dlv_valid (dlv_valid),
  .dlv_data  (dlv_data),
  .dlv_hops  (dlv_hops),
  .dlv_ready (dlv_ready),
  .nout_v    (nout_v),
  .nout_rdy  (nout_rdy),
  .nout_msg  (nout_msg)
);

// File: tb/test_hcube_net.sv
`timescale 1ns/1ps
module test_hcube_net;
  localparam int DIM = 3;
  localparam int PW  = 8;
  localparam int NODES = 8;
  localparam int HW  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic [NODES-1:0]     inj_valid, inj_ready, dlv_valid, dlv_ready;
  logic [NODES*DIM-1:0] inj_dst;
  logic [NODES*PW-1:0]  inj_data, dlv_data;
  logic [NODES*HW-1:0]  dlv_hops;

  hcube_net #(.DIM(DIM), .PW(PW)) i_hcube_net (
    .clk, .rst_n, .inj_valid, .inj_dst, .inj_data, .inj_ready,
    .dlv_valid, .dlv_data, .dlv_hops, .dlv_ready
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int got_n;
  int got_d [8];
  int got_h [8];

  // {src, dst, payload, expected hops}
  localparam logic [15:0] VEC [10] = '{
    {3'd3, 3'd6, 8'hA5, 2'd2},
    {3'd0, 3'd7, 8'h3C, 2'd3},
    {3'd7, 3'd0, 8'hC3, 2'd3},
    {3'd5, 3'd5, 8'h55, 2'd0},
    {3'd1, 3'd0, 8'h01, 2'd1},
    {3'd4, 3'd2, 8'h42, 2'd2},
    {3'd6, 3'd1, 8'h61, 2'd3},
    {3'd2, 3'd3, 8'h23, 2'd1},
    {3'd0, 3'd0, 8'hFF, 2'd0},
    {3'd5, 3'd2, 8'h52, 2'd3}
  };

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(int s, int d, int data);
    @(negedge clk);
    inj_valid[s] = 1'b1;
    inj_dst[s*DIM +: DIM] = DIM'(d);
    inj_data[s*PW +: PW]  = PW'(data);
    for (int w = 0; w < 50 && !inj_ready[s]; w++) @(negedge clk);
    @(negedge clk);
    inj_valid[s] = 1'b0;
  endtask

  task automatic expect_dlv(int d, int data, int hops, string tag);
    int w;
    for (w = 0; w < 40 && !dlv_valid[d]; w++) @(negedge clk);
    chk(dlv_valid[d] == 1'b1, {tag, " R1 delivery seen"}, int'(dlv_valid[d]), 1);
    chk(int'(dlv_data[d*PW +: PW]) == data, {tag, " R1 payload"}, int'(dlv_data[d*PW +: PW]), data);
    chk(int'(dlv_hops[d*HW +: HW]) == hops, {tag, " R3 hops"}, int'(dlv_hops[d*HW +: HW]), hops);
    @(negedge clk);
  endtask

  // raise ready on node d at a negedge and log what comes out
  task automatic drain(int d);
    got_n = 0;
    dlv_ready[d] = 1'b1;
    for (int c = 0; c < 12; c++) begin
      if (dlv_valid[d] && got_n < 8) begin
        got_d[got_n] = int'(dlv_data[d*PW +: PW]);
        got_h[got_n] = int'(dlv_hops[d*HW +: HW]);
        got_n++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    inj_valid = '0;
    inj_dst = '0;
    inj_data = '0;
    dlv_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    chk(dlv_valid == '0, "R8 no delivery after reset", int'(dlv_valid), 0);
    chk(inj_ready == '1, "R8 all injection ready after reset", int'(inj_ready), 255);

    // table walk (R1, R3, R4)
    for (int v = 0; v < 10; v++) begin
      send(int'(VEC[v][15:13]), int'(VEC[v][12:10]), int'(VEC[v][9:2]));
      expect_dlv(int'(VEC[v][12:10]), int'(VEC[v][9:2]), int'(VEC[v][1:0]),
                 (VEC[v][1:0] == 2'd0) ? "table R4 self" : "table");
    end

    // every pair: hop count equals Hamming distance (R3)
    for (int s = 0; s < NODES; s++) begin
      for (int d = 0; d < NODES; d++) begin
        send(s, d, (s * 16 + d) ^ 8'h5A);
        expect_dlv(d, (s * 16 + d) ^ 8'h5A, $countones(s ^ d), "pair R3");
      end
    end

    // R5 R6 R7 R9: three inputs contend for node 0 local output
    dlv_ready[0] = 1'b0;
    @(negedge clk);
    inj_valid[2:0] = 3'b111;
    inj_dst[0 +: DIM] = 3'd0; inj_dst[3 +: DIM] = 3'd0; inj_dst[6 +: DIM] = 3'd0;
    inj_data[0 +: PW] = 8'h10; inj_data[8 +: PW] = 8'h11; inj_data[16 +: PW] = 8'h12;
    @(negedge clk);
    inj_valid[2:0] = 3'b000;
    repeat (4) @(negedge clk);
    chk(inj_ready[0] == 1'b0, "R9 local slot busy", int'(inj_ready[0]), 0);
    chk(dlv_valid[0] == 1'b1, "R7 stalled valid held", int'(dlv_valid[0]), 1);
    chk(int'(dlv_data[0 +: PW]) == 8'h10, "R7 stalled payload", int'(dlv_data[0 +: PW]), 8'h10);
    repeat (3) @(negedge clk);
    chk(int'(dlv_data[0 +: PW]) == 8'h10, "R7 payload still stable", int'(dlv_data[0 +: PW]), 8'h10);
    drain(0);
    chk(got_n == 3, "R6 all three delivered once", got_n, 3);
    chk(got_d[0] == 8'h10, "R5 first winner local", got_d[0], 8'h10);
    chk(got_d[1] == 8'h11, "R5 then dimension 0 link", got_d[1], 8'h11);
    chk(got_d[2] == 8'h12, "R5 then dimension 1 link", got_d[2], 8'h12);
    chk(got_h[1] == 1 && got_h[2] == 1, "R3 neighbour hops", got_h[1] + got_h[2], 2);
    chk(inj_ready[0] == 1'b1, "R9 slot free again", int'(inj_ready[0]), 1);

    // R2: 011 -> 110 must share the 010 -> 110 link and queue behind it
    dlv_ready[6] = 1'b0;
    @(negedge clk);
    inj_valid[2] = 1'b1; inj_valid[3] = 1'b1;
    inj_dst[6 +: DIM] = 3'd6; inj_dst[9 +: DIM] = 3'd6;
    inj_data[16 +: PW] = 8'h22; inj_data[24 +: PW] = 8'h33;
    @(negedge clk);
    inj_valid[2] = 1'b0; inj_valid[3] = 1'b0;
    repeat (5) @(negedge clk);
    drain(6);
    chk(got_n == 2, "R6 both merged messages delivered", got_n, 2);
    chk(got_d[0] == 8'h22, "R2 message from 010 first", got_d[0], 8'h22);
    chk(got_d[1] == 8'h33, "R2 message from 011 routed via 010", got_d[1], 8'h33);
    chk(got_h[1] == 2, "R2 two hops from 011", got_h[1], 2);
    chk(dlv_valid == '0, "R6 nothing left over", int'(dlv_valid), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule